// File: doc/BRIEF.md
# Ripple Bit-Slice Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit. It is built from identical one-bit cells joined by a carry chain. With the default width of eight, each cell sees one bit of each operand, the carry from the cell below, a mode flag and a two-bit operation code. Each cell returns one result bit and a carry for the cell above. The carry-in of the unit enters the lowest cell. The carry leaving the highest cell becomes the top bit of a result that is one bit wider than the operands.

The mode flag selects between two groups of operations:

- **Bitwise group.** Pass, complement, exclusive-or and equivalence. The carry-in has no effect and the top result bit stays at zero.
- **Arithmetic group.** Each cell works as a full adder. The first addend is A or its complement, chosen by op bit 0. The second addend is zero or B, chosen by op bit 1. The carry-in adds one. This gives increment, negation, addition and the difference B minus A from one set of gates.

Top module: `bsalu`

## Requirements
- R1: With `mode_arith`=0 and `op_sel`=2'b00, `result[7:0]` equals `a_in` and `result[8]` is 0.
- R2: With `mode_arith`=0 and `op_sel`=2'b01, `result[7:0]` equals the bitwise complement of `a_in` and `result[8]` is 0.
- R3: With `mode_arith`=0, `op_sel`=2'b10 gives `a_in ^ b_in` and `op_sel`=2'b11 gives `~(a_in ^ b_in)` on `result[7:0]`, with `result[8]`=0.
- R4: With `mode_arith`=0, `carry_in` has no effect on any bit of `result`, and `result[8]` is 0 for every operation code.
- R5: With `mode_arith`=1 and `carry_in`=0, `op_sel`=2'b00 gives `result`=`a_in` and `op_sel`=2'b01 gives `result`=`~a_in`, each zero-extended to 9 bits.
- R6: With `mode_arith`=1 and `carry_in`=0, `op_sel`=2'b10 gives the 9-bit sum `a_in + b_in`, and `op_sel`=2'b11 gives the 9-bit sum `~a_in + b_in`.
- R7: With `mode_arith`=1 and `carry_in`=1, `op_sel`=2'b00 gives `a_in + 1` and `op_sel`=2'b01 gives `~a_in + 1`, as 9-bit sums. For example, `a_in`=0 with `op_sel`=2'b01 gives 9'h100.
- R8: With `mode_arith`=1 and `carry_in`=1, `op_sel`=2'b10 gives `a_in + b_in + 1` and `op_sel`=2'b11 gives `~a_in + b_in + 1`. The low eight bits of the latter equal `b_in - a_in` modulo 256.
- R9: `carry_in` enters the least significant cell, and `result[8]` is the carry leaving the most significant cell. A carry into bit 0 can ripple through all eight cells to the top bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 8 | First operand A |
| b_in | input | 8 | Second operand B |
| carry_in | input | 1 | Carry into the lowest cell |
| mode_arith | input | 1 | 1 selects the arithmetic group, 0 selects the bitwise group |
| op_sel | input | 2 | Operation code; bit 1 gates B, bit 0 complements A |
| result | output | 9 | Result bits 7:0, with the final carry in bit 8 |

## Verification
Two functions can act at once on the same vector: the full ripple of the carry chain and the complement of A. The clearest case is `~a_in + 1` with `a_in` at zero, where a carry from bit 0 has to cross every cell and land in `result[8]`. The same pairing, with the carry gated off, appears when the bitwise group is driven with `carry_in` high. The bench covers every combination of operands, mode, carry and operation code. It judges each result against 9-bit arithmetic on masked operands, computed independently in the bench, and adds named corner vectors for the long ripple and for B minus A.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;

  typedef enum logic [1:0] {
    OP_KEEP_A   = 2'b00,
    OP_FLIP_A   = 2'b01,
    OP_WITH_B   = 2'b10,
    OP_FLIP_W_B = 2'b11
  } bsalu_op_e;

  // two-bit sum of three single-bit addends
  function automatic logic [1:0] tri_add(input logic x, input logic y, input logic z);
    return {1'b0, x} + {1'b0, y} + {1'b0, z};
  endfunction

endpackage

// File: rtl/bsalu_slice.sv
module bsalu_slice
  import bsalu_pkg::*;
(
  input  logic a_bit,
  input  logic b_bit,
  input  logic c_in,
  input  logic arith,
  input  logic s1,
  input  logic s0,
  output logic f_bit,
  output logic c_out
);

  logic first_op;   // A or NOT A
  logic second_op;  // 0 or B
  logic carry_eff;  // carry gated by mode
  logic half_sum;   // shared by both groups

  assign first_op  = a_bit ^ s0;
  assign second_op = b_bit & s1;
  assign carry_eff = c_in & arith;
  assign half_sum  = first_op ^ second_op;
  assign f_bit     = half_sum ^ carry_eff;
  assign c_out     = arith & ((first_op & second_op) | (carry_eff & half_sum));

  always_comb begin
    if (arith) begin
      // R6: cell behaves as a full adder in arithmetic mode
      assert_slice_fulladd_R6: assert ({c_out, f_bit} == tri_add(first_op, second_op, c_in));
    end else begin
      // R4: no carry produced and incoming carry ignored
      assert_slice_nocarry_R4: assert (!c_out && (f_bit == (a_bit ^ (b_bit & s1) ^ s0)));
    end
  end

endmodule

// File: rtl/bsalu_chain.sv
module bsalu_chain
  import bsalu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             cin,
  input  logic             arith,
  input  logic [1:0]       sel,
  output logic [WIDTH-1:0] bits,
  output logic             cout
);

  localparam int CW = WIDTH + 1;

  logic [WIDTH:0] ripple;

  assign ripple[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    bsalu_slice u_cell (
      .a_bit (opa[i]),
      .b_bit (opb[i]),
      .c_in  (ripple[i]),
      .arith (arith),
      .s1    (sel[1]),
      .s0    (sel[0]),
      .f_bit (bits[i]),
      .c_out (ripple[i+1])
    );
  end

  assign cout = ripple[WIDTH];

  function automatic logic [CW-1:0] wide_sum(input logic [WIDTH-1:0] x,
                                             input logic [WIDTH-1:0] y,
                                             input logic [1:0] s,
                                             input logic c);
    logic [CW-1:0] xe, ye;
    xe = {1'b0, (s[0] ? ~x : x)};
    ye = {1'b0, (s[1] ? y : '0)};
    return xe + ye + CW'(c);
  endfunction

  always_comb begin
    if (arith) begin
      // R9: ripple of all cells equals one wide addition
      assert_chain_ripple_R9: assert ({cout, bits} == wide_sum(opa, opb, sel, cin));
    end else begin
      // R4: top carry stays low in the bitwise group
      assert_chain_topzero_R4: assert (cout == 1'b0);
    end
  end

endmodule

// File: rtl/bsalu.sv
module bsalu
  import bsalu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             carry_in,
  input  logic             mode_arith,
  input  logic [1:0]       op_sel,
  output logic [WIDTH:0]   result
);

  logic [WIDTH-1:0] low_bits;
  logic             top_carry;
  bsalu_op_e        op_code;

  assign op_code = bsalu_op_e'(op_sel);

  bsalu_chain #(.WIDTH(WIDTH)) u_chain (
    .opa   (a_in),
    .opb   (b_in),
    .cin   (carry_in),
    .arith (mode_arith),
    .sel   (op_sel),
    .bits  (low_bits),
    .cout  (top_carry)
  );

  assign result = {top_carry, low_bits};

  always_comb begin
    if (!mode_arith) begin
      unique case (op_code)
        OP_KEEP_A:   assert_logic_pass_R1: assert (result == {1'b0, a_in});
        OP_FLIP_A:   assert_logic_inv_R2:  assert (result == {1'b0, ~a_in});
        OP_WITH_B:   assert_logic_xor_R3:  assert (result == {1'b0, a_in ^ b_in});
        OP_FLIP_W_B: assert_logic_xnor_R3: assert (result == {1'b0, ~(a_in ^ b_in)});
        default: ;
      endcase
    end else if (carry_in && op_code == OP_FLIP_W_B) begin
      // R8: difference B minus A
      assert_diff_R8: assert (result[WIDTH-1:0] == WIDTH'(b_in - a_in));
    end
  end

endmodule

// File: tb/bsalu_tb_top.sv
`timescale 1ns/100ps
module bsalu_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] a_in = '0;
  logic [7:0] b_in = '0;
  logic       carry_in = 1'b0;
  logic       mode_arith = 1'b0;
  logic [1:0] op_sel = 2'b00;
  logic [8:0] result;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bsalu dut_i (
    .a_in       (a_in),
    .b_in       (b_in),
    .carry_in   (carry_in),
    .mode_arith (mode_arith),
    .op_sel     (op_sel),
    .result     (result)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s a=%02h b=%02h m=%0d c=%0d s=%0d actual=%03h expected=%03h",
               req, a_in, b_in, mode_arith, carry_in, op_sel, act, exp);
    end
  endtask

  function automatic logic [8:0] model(input logic [7:0] a, input logic [7:0] b,
                                       input logic m, input logic c, input logic [1:0] s);
    int ea, eb, sum;
    if (!m) begin
      case (s)
        2'b00: return {1'b0, a};
        2'b01: return {1'b0, 8'(255 - a)};
        2'b10: return {1'b0, a ^ b};
        default: return {1'b0, 8'(255 - (a ^ b))};
      endcase
    end
    ea = s[0] ? (255 - int'(a)) : int'(a);
    eb = s[1] ? int'(b) : 0;
    sum = ea + eb + int'(c);
    return 9'(sum % 512);
  endfunction

  function automatic string tag(input logic m, input logic c, input logic [1:0] s);
    if (!m) return (s == 2'b00) ? "R1" : (s == 2'b01) ? "R2" : "R3";
    if (!c) return s[1] ? "R6" : "R5";
    return s[1] ? "R8" : "R7";
  endfunction

  task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic m,
                       input logic c, input logic [1:0] s);
    a_in = a; b_in = b; mode_arith = m; carry_in = c; op_sel = s;
    #0.5;
  endtask

  initial begin
    #2.5;
    check("reset R1", result, 9'h000);
    @(posedge clk); @(posedge clk);
    rst = 1'b0;
    #2;
    // R9: long ripple from bit 0 to top through complement of zero
    apply(8'h00, 8'h00, 1'b1, 1'b1, 2'b01); check("R9 ripple", result, 9'h100); #0.5;
    apply(8'hFF, 8'h00, 1'b1, 1'b1, 2'b00); check("R7 inc wrap", result, 9'h100); #0.5;
    apply(8'h05, 8'h03, 1'b1, 1'b1, 2'b11); check("R8 b-a", result, 9'h0FE); #0.5;
    apply(8'h03, 8'h05, 1'b1, 1'b1, 2'b11); check("R8 b-a pos", result, 9'h102); #0.5;
    apply(8'hFF, 8'h01, 1'b1, 1'b0, 2'b10); check("R6 add carry", result, 9'h100); #0.5;
    // R4: carry_in ignored in bitwise group
    apply(8'hFF, 8'hFF, 1'b0, 1'b1, 2'b00); check("R4 cin ignored", result, 9'h0FF); #0.5;
    apply(8'h00, 8'h00, 1'b0, 1'b1, 2'b01); check("R4 cin ignored", result, 9'h0FF); #0.5;
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 2; c++)
        for (int s = 0; s < 4; s++)
          for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++) begin
              apply(8'(a), 8'(b), 1'(m), 1'(c), 2'(s));
              check(tag(1'(m), 1'(c), 2'(s)), result,
                    model(8'(a), 8'(b), 1'(m), 1'(c), 2'(s)));
              #0.5;
            end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R9 actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule